// File: doc/BRIEF.md
# Interrupt Source PQ State Buffer

This block keeps a two-bit coalescing state for each of `NUM_SRC` interrupt sources. The high bit (P) says an event has been handed to the router and is waiting for an end-of-interrupt. The low bit (Q) records that the source fired again while P was set. A trigger on an idle source produces a notification that carries the source number. Triggers on a busy source are only remembered. An EOI either retires the source or re-arms it, depending on Q. Each source is either edge-style (one event for every cycle its trigger input is high) or level-style. Level-style sources also keep an assertion bit that follows the input.

Software reaches the state through one load/store port. The source number sits above bit `ESB_SHIFT` of the address, and bits [11:8] select the operation. An odd `ESB_SHIFT` splits each source's region into two halves. The lower half is the trigger page and the upper half is the management page. An even `ESB_SHIFT` uses one shared page for both. Pending notifications leave through a small FIFO with a valid/ready handshake toward the router.

Top module: `esb_pq_buffer`

## Requirements
- R1: After reset every source reads PQ = 00, `ntf_valid_o` is low and `rsp_valid_o` is low.
- R2: A trigger moves an edge-style source as follows, with encodings idle 00, pending 10, queued 11 and off 01. 00 goes to 10 and raises one notification. 10 goes to 11, 11 stays 11 and 01 stays 01, and none of these three notifies.
- R3: An EOI (load at op bits 00, or an enabled store-EOI) moves 10 to 00 and 11 to 10, and the 11 case raises a fresh notification. It leaves 00 and 01 unchanged.
- R4: A load produces `rsp_valid_o` for exactly one cycle, in the cycle after the request; stores produce no response. The response holds the state before the operation in bits [1:0], the level-source assertion bit in bit 2, and zeros elsewhere.
- R5: A load to a management page decodes address bits [11:10] as follows: 00 is EOI, 01 and 10 are read-only, and 11 forces PQ to address bits [9:8]. The returned value is always the prior state.
- R6: A store to the management page with address bits [11:8] = 4 performs an EOI only while `store_eoi_en_i` is high. Otherwise it is ignored, and any other store to the management page is ignored too.
- R7: The source number is `addr >> ESB_SHIFT`. In two-page mode bit `ESB_SHIFT-1` selects the management page. A store to the trigger page triggers that source. A load from the trigger page returns all ones and changes nothing.
- R8: A request whose source number is `NUM_SRC` or above returns all ones on a load and changes no source state.
- R9: A level-style source triggers only on a rising input. Its assertion bit follows the input. An EOI that leaves it at 00 while the input is still high moves it to 10 and notifies again.
- R10: Notifications keep `ntf_valid_o` and `ntf_src_o` stable until accepted. Pending sources enter the FIFO one per cycle, lowest number first. A source that cannot enter a full FIFO waits and is never lost.
- R11: When a hardware trigger and a load hit the same source in the same cycle, the trigger is applied first. The load then returns, and operates on, the post-trigger state.
- R12: Any number of triggers between two EOIs yields at most one notification for a source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_trig_i | input | NUM_SRC | Per-source trigger (edge sources: event per high cycle; level sources: line level) |
| store_eoi_en_i | input | 1 | Enables EOI by store |
| req_valid_i | input | 1 | Load/store request valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Request address |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_data_o | output | DATA_W | Load response data |
| ntf_valid_o | output | 1 | Notification valid |
| ntf_src_o | output | SRC_W | Notified source number |
| ntf_ready_i | input | 1 | Router accepts notification |

## Verification
A hardware trigger and a software operation can land on the same source in the same clock. An EOI or a forced write could then race an event that is arriving. The bench provokes this by raising a source's trigger in the very cycle of a load EOI on a pending source, and of a read on an idle one. It judges the result by the returned value, which must show the post-trigger state (11 and 10 respectively). It also checks the final state and whether a fresh notification appears.

// File: rtl/esb_pkg.sv
package esb_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_EOI,
        OP_GET,
        OP_SET
    } esb_op_e;

    localparam logic [1:0] PQ_IDLE   = 2'b00;
    localparam logic [1:0] PQ_OFF    = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;

    typedef struct packed {
        logic [1:0] pq;
        logic       lvl;
        logic       send;
    } cell_state_t;

    function automatic logic [1:0] pq_after_trigger(input logic [1:0] pq);
        case (pq)
            PQ_IDLE: return PQ_PEND;
            PQ_PEND: return PQ_QUEUED;
            default: return pq;
        endcase
    endfunction

    function automatic logic [1:0] pq_after_eoi(input logic [1:0] pq);
        case (pq)
            PQ_PEND:   return PQ_IDLE;
            PQ_QUEUED: return PQ_PEND;
            default:   return pq;
        endcase
    endfunction

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
    import esb_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int ESB_SHIFT = 13,
    parameter int SRC_W     = $clog2(NUM_SRC),
    parameter int ADDR_W    = ESB_SHIFT + SRC_W + 1
) (
    input  logic              valid_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              store_eoi_en_i,
    output esb_op_e           op_o,
    output logic [SRC_W:0]    src_o,
    output logic              in_range_o,
    output logic [1:0]        set_pq_o,
    output logic              ones_o
);

    localparam bit TWO_PAGE = (ESB_SHIFT % 2) == 1;

    logic       page_hi;
    logic       mgmt_page;
    logic       trig_page;
    logic [3:0] nib;

    always_comb begin
        src_o      = addr_i[ADDR_W-1:ESB_SHIFT];
        in_range_o = (int'(src_o) < NUM_SRC);
        page_hi    = addr_i[ESB_SHIFT-1];
        mgmt_page  = TWO_PAGE ? page_hi : 1'b1;
        trig_page  = TWO_PAGE ? !page_hi : 1'b1;
        nib        = addr_i[11:8];
        set_pq_o   = nib[1:0];
        op_o       = OP_NONE;
        ones_o     = 1'b0;
        if (valid_i) begin
            if (we_i) begin
                if (in_range_o) begin
                    if (mgmt_page && nib == 4'h4) begin
                        op_o = store_eoi_en_i ? OP_EOI : OP_NONE;
                    end else if (trig_page) begin
                        op_o = OP_TRIG;
                    end
                end
            end else if (!in_range_o || !mgmt_page) begin
                ones_o = 1'b1;
            end else begin
                case (nib[3:2])
                    2'b00:   op_o = OP_EOI;
                    2'b11:   op_o = OP_SET;
                    default: op_o = OP_GET;
                endcase
            end
        end
    end

endmodule

// File: rtl/esb_src_cell.sv
module esb_src_cell
    import esb_pkg::*;
#(
    parameter bit IS_LSI = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       sel_i,
    input  esb_op_e    op_i,
    input  logic [1:0] set_pq_i,
    input  logic       grant_i,
    output logic [1:0] pq_mid_o,
    output logic       lvl_o,
    output logic       send_o
);

    cell_state_t st_q, st_d;
    logic        evt;
    logic        new_send;
    logic [1:0]  pq_mid;

    always_comb begin
        st_d     = st_q;
        new_send = 1'b0;
        evt      = (IS_LSI ? (trig_i && !st_q.lvl) : trig_i) || (sel_i && op_i == OP_TRIG);
        pq_mid   = st_q.pq;
        if (evt) begin
            pq_mid   = pq_after_trigger(st_q.pq);
            new_send = (st_q.pq == PQ_IDLE);
        end
        st_d.pq = pq_mid;
        if (sel_i) begin
            case (op_i)
                OP_EOI: begin
                    st_d.pq = pq_after_eoi(pq_mid);
                    if (pq_mid == PQ_QUEUED) new_send = 1'b1;
                    if (IS_LSI && trig_i && st_d.pq == PQ_IDLE) begin
                        st_d.pq  = PQ_PEND;
                        new_send = 1'b1;
                    end
                end
                OP_SET:  st_d.pq = set_pq_i;
                default: ;
            endcase
        end
        st_d.lvl  = IS_LSI ? trig_i : 1'b0;
        st_d.send = (st_q.send && !grant_i) || new_send;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pq_mid_o = pq_mid;
    assign lvl_o    = st_q.lvl;
    assign send_o   = st_q.send;

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pq == PQ_OFF && !sel_i) |=> (st_q.pq == PQ_OFF)); // R2

    AST_SEND_NEEDS_P: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.send) |-> st_q.pq[1]); // R12

endmodule

// File: rtl/esb_ntf_fifo.sv
module esb_ntf_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic         full_o,
    output logic         empty_o,
    output logic [W-1:0] data_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (push_i) begin
            f_d.mem[f_q.wr] = data_i;
            f_d.wr = (f_q.wr == LAST) ? '0 : f_q.wr + 1'b1;
        end
        if (pop_i) begin
            f_d.rd = (f_q.rd == LAST) ? '0 : f_q.rd + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign full_o  = (f_q.cnt == FULL_CNT);
    assign empty_o = (f_q.cnt == '0);
    assign data_o  = f_q.mem[f_q.rd];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R10

endmodule

// File: rtl/esb_pq_buffer.sv
module esb_pq_buffer
    import esb_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int ESB_SHIFT  = 13,
    parameter int FIFO_DEPTH = 4,
    parameter int DATA_W     = 64,
    parameter logic [NUM_SRC-1:0] LSI_MASK = ~({NUM_SRC{1'b1}} >> (NUM_SRC / 2)),
    parameter int SRC_W      = $clog2(NUM_SRC),
    parameter int ADDR_W     = ESB_SHIFT + SRC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_trig_i,
    input  logic               store_eoi_en_i,
    input  logic               req_valid_i,
    input  logic               req_we_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output logic               rsp_valid_o,
    output logic [DATA_W-1:0]  rsp_data_o,
    output logic               ntf_valid_o,
    output logic [SRC_W-1:0]   ntf_src_o,
    input  logic               ntf_ready_i
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    esb_op_e              dec_op;
    logic [SRC_W:0]       dec_src;
    logic                 dec_in_range;
    logic [1:0]           dec_set_pq;
    logic                 dec_ones;

    logic [NUM_SRC-1:0]      sel;
    logic [NUM_SRC-1:0][1:0] pq_mid;
    logic [NUM_SRC-1:0]      lvl;
    logic [NUM_SRC-1:0]      send;
    logic [NUM_SRC-1:0]      grant;
    logic [SRC_W-1:0]        gnt_idx;
    logic                    gnt_found;
    logic                    push;
    logic                    fifo_full;
    logic                    fifo_empty;

    rsp_t rsp_q, rsp_d;

    esb_addr_decode #(
        .NUM_SRC  (NUM_SRC),
        .ESB_SHIFT(ESB_SHIFT),
        .SRC_W    (SRC_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .valid_i       (req_valid_i),
        .we_i          (req_we_i),
        .addr_i        (req_addr_i),
        .store_eoi_en_i(store_eoi_en_i),
        .op_o          (dec_op),
        .src_o         (dec_src),
        .in_range_o    (dec_in_range),
        .set_pq_o      (dec_set_pq),
        .ones_o        (dec_ones)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        assign sel[g] = dec_in_range && (dec_src == (SRC_W + 1)'(g));
        esb_src_cell #(.IS_LSI(LSI_MASK[g])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_i  (src_trig_i[g]),
            .sel_i   (sel[g]),
            .op_i    (dec_op),
            .set_pq_i(dec_set_pq),
            .grant_i (grant[g]),
            .pq_mid_o(pq_mid[g]),
            .lvl_o   (lvl[g]),
            .send_o  (send[g])
        );
    end

    always_comb begin
        gnt_found = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (send[i] && !gnt_found) begin
                gnt_found = 1'b1;
                gnt_idx   = SRC_W'(i);
            end
        end
        push  = gnt_found && !fifo_full;
        grant = '0;
        if (push) grant[gnt_idx] = 1'b1;
    end

    esb_ntf_fifo #(
        .DEPTH(FIFO_DEPTH),
        .W    (SRC_W)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .data_i (gnt_idx),
        .pop_i  (ntf_valid_o && ntf_ready_i),
        .full_o (fifo_full),
        .empty_o(fifo_empty),
        .data_o (ntf_src_o)
    );

    assign ntf_valid_o = !fifo_empty;

    always_comb begin
        rsp_d.valid = req_valid_i && !req_we_i;
        rsp_d.data  = '0;
        if (rsp_d.valid) begin
            if (dec_ones) begin
                rsp_d.data = '1;
            end else begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (sel[i]) begin
                        rsp_d.data[1:0] = pq_mid[i];
                        rsp_d.data[2]   = lvl[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_data_o  = rsp_q.data;

    AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && !req_we_i)); // R4

    AST_NTF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid_o && !ntf_ready_i) |=> (ntf_valid_o && $stable(ntf_src_o))); // R10

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R10

endmodule

// File: tb/esb_pq_buffer_bench.sv
module esb_pq_buffer_bench;

    localparam int NUM_SRC = 8;
    localparam int SHIFT   = 13;
    localparam int SRC_W   = 3;
    localparam int ADDR_W  = SHIFT + SRC_W + 1;
    localparam logic [63:0] ONES = '1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] trig = '0;
    logic               seoi = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_we = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               rsp_valid;
    logic [63:0]        rsp_data;
    logic               ntf_valid;
    logic [SRC_W-1:0]   ntf_src;
    logic               ntf_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    esb_pq_buffer #(
        .NUM_SRC(NUM_SRC), .ESB_SHIFT(SHIFT), .FIFO_DEPTH(4), .DATA_W(64),
        .LSI_MASK(8'hF0)
    ) u_esb_pq_buffer (
        .clk(clk), .rst_n(rst_n), .src_trig_i(trig), .store_eoi_en_i(seoi),
        .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .ntf_valid_o(ntf_valid), .ntf_src_o(ntf_src), .ntf_ready_i(ntf_ready)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] adr(input int src, input bit mgmt, input int off);
        return ADDR_W'((src << SHIFT) | (int'(mgmt) << (SHIFT - 1)) | off);
    endfunction

    task automatic load(input int src, input bit mgmt, input int off,
                        input logic [NUM_SRC-1:0] pulse, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = adr(src, mgmt, off);
        trig = trig | pulse;
        @(negedge clk);
        req_valid = 1'b0;
        trig = trig & ~pulse;
        d = rsp_data;
    endtask

    task automatic store(input int src, input bit mgmt, input int off);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = adr(src, mgmt, off);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] m);
        @(negedge clk); trig = trig | m;
        @(negedge clk); trig = trig & ~m;
    endtask

    task automatic get(input int src, output logic [63:0] d);
        load(src, 1'b1, 'h800, '0, d);
    endtask

    task automatic setpq(input int src, input int v);
        logic [63:0] d;
        load(src, 1'b1, 'hC00 | (v << 8), '0, d);
    endtask

    task automatic expect_ntf(input string r, input int src);
        int waited = 0;
        @(negedge clk); ntf_ready = 1'b1;
        while (!ntf_valid && waited < 20) begin
            @(negedge clk); waited++;
        end
        chk(r, ntf_valid ? 64'(ntf_src) : 64'hFFFF, 64'(src));
        @(negedge clk); ntf_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string r);
        repeat (4) @(negedge clk);
        chk(r, 64'(ntf_valid), 64'd0);
    endtask

    function automatic int trig_next(input int s);
        return (s == 0) ? 2 : (s == 2) ? 3 : s;
    endfunction

    function automatic int eoi_next(input int s);
        return (s == 2) ? 0 : (s == 3) ? 2 : s;
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        $display("FAIL watchdog expired");
        n_chk++; n_fail++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 ntf_valid", 64'(ntf_valid), 0);
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        for (int s = 0; s < NUM_SRC; s++) begin
            get(s, d); chk("R1 pq", d, 0);
        end

        // R4: response timing
        load(0, 1'b1, 'h800, '0, d);
        chk("R4 rsp_valid on load", 64'(rsp_valid), 1);
        store(0, 1'b1, 'h000);
        chk("R4 no rsp on store", 64'(rsp_valid), 0);

        // R2: trigger sweep on edge sources
        for (int s = 0; s < 4; s++) begin
            for (int st = 0; st < 4; st++) begin
                setpq(s, st);
                pulse(NUM_SRC'(1) << s);
                get(s, d); chk("R2 trigger state", d, 64'(trig_next(st)));
                if (st == 0) expect_ntf("R2 notify", s);
                else         expect_quiet("R2 no notify");
                setpq(s, 0);
            end
        end

        // R3/R4: load-EOI sweep
        for (int s = 0; s < 4; s++) begin
            for (int st = 0; st < 4; st++) begin
                setpq(s, st);
                load(s, 1'b1, 'h000, '0, d); chk("R4 prior state", d, 64'(st));
                get(s, d); chk("R3 eoi state", d, 64'(eoi_next(st)));
                if (st == 3) expect_ntf("R3 re-notify", s);
                else         expect_quiet("R3 no notify");
                setpq(s, 0);
            end
        end

        // R5: offset decode sweep
        for (int nib = 0; nib < 16; nib++) begin
            int exp_st;
            setpq(0, 3);
            load(0, 1'b1, nib << 8, '0, d); chk("R5 returns prior", d, 3);
            exp_st = (nib < 4) ? 2 : (nib >= 12) ? (nib & 3) : 3;
            get(0, d); chk("R5 resulting state", d, 64'(exp_st));
            if (nib < 4) expect_ntf("R5 eoi notify", 0);
            setpq(0, 0);
        end

        // R6: store EOI gating
        seoi = 1'b0;
        setpq(1, 2); store(1, 1'b1, 'h400);
        get(1, d); chk("R6 disabled store eoi", d, 2);
        seoi = 1'b1;
        store(1, 1'b1, 'h400);
        get(1, d); chk("R6 enabled store eoi", d, 0);
        setpq(1, 3); store(1, 1'b1, 'h400);
        get(1, d); chk("R6 store eoi queued", d, 2);
        expect_ntf("R6 store eoi notify", 1);
        setpq(1, 0);
        store(1, 1'b1, 'h000);
        get(1, d); chk("R6 other mgmt store ignored", d, 0);
        expect_quiet("R6 other mgmt store quiet");

        // R7: trigger page
        setpq(2, 0); store(2, 1'b0, 'h000);
        get(2, d); chk("R7 trigger page store", d, 2);
        expect_ntf("R7 trigger page notify", 2);
        load(2, 1'b0, 'h000, '0, d); chk("R7 trigger page load", d, ONES);
        get(2, d); chk("R7 trigger page load no effect", d, 2);
        setpq(2, 0);

        // R8: out of range
        for (int s = NUM_SRC; s < 2 * NUM_SRC; s++) begin
            load(s, 1'b1, 'h800, '0, d); chk("R8 out of range load", d, ONES);
        end
        store(9, 1'b0, 'h000);
        load(9, 1'b1, 'hF00, '0, d);
        expect_quiet("R8 out of range no notify");
        get(1, d); chk("R8 alias untouched", d, 0);

        // R9: level source
        @(negedge clk); trig[5] = 1'b1;
        @(negedge clk);
        get(5, d); chk("R9 level rise", d, 6);
        expect_ntf("R9 level notify", 5);
        get(5, d); chk("R9 level held", d, 6);
        expect_quiet("R9 no repeat");
        load(5, 1'b1, 'h000, '0, d); chk("R9 eoi prior", d, 6);
        get(5, d); chk("R9 eoi still asserted", d, 6);
        expect_ntf("R9 re-notify", 5);
        @(negedge clk); trig[5] = 1'b0;
        load(5, 1'b1, 'h000, '0, d); chk("R9 eoi prior low", d, 2);
        get(5, d); chk("R9 eoi released", d, 0);
        expect_quiet("R9 released quiet");

        // R11: same-cycle trigger and load
        setpq(1, 2);
        load(1, 1'b1, 'h000, 8'h02, d); chk("R11 eoi sees trigger", d, 3);
        get(1, d); chk("R11 eoi result", d, 2);
        expect_ntf("R11 notify", 1);
        setpq(1, 0);
        setpq(2, 0);
        load(2, 1'b1, 'h800, 8'h04, d); chk("R11 get sees trigger", d, 2);
        expect_ntf("R11 get notify", 2);
        setpq(2, 0);

        // R12: coalescing
        setpq(0, 0);
        pulse(8'h01); pulse(8'h01); pulse(8'h01);
        get(0, d); chk("R12 coalesced state", d, 3);
        expect_ntf("R12 single notify", 0);
        expect_quiet("R12 no second notify");
        setpq(0, 0);

        // R10: FIFO full, hold, order
        @(negedge clk); trig = 8'hFF;
        @(negedge clk); trig = 8'hF0;
        repeat (6) @(negedge clk);
        chk("R10 head valid", 64'(ntf_valid), 1);
        chk("R10 head src", 64'(ntf_src), 0);
        repeat (3) @(negedge clk);
        chk("R10 head stable", 64'(ntf_src), 0);
        for (int k = 0; k < NUM_SRC; k++) expect_ntf("R10 order", k);
        expect_quiet("R10 drained");
        @(negedge clk); trig = '0;
        for (int s = 0; s < NUM_SRC; s++) load(s, 1'b1, 'h000, '0, d);
        get(7, d); chk("R10 cleanup", d, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule